// File: doc/BRIEF.md
# Eight-Level Programmable Priority Interrupt Controller

This block gathers eight level-sensitive interrupt request lines into a request register, removes the levels that software has masked, and picks one winner among the rest. The bus master sees a single interrupt output. That output is raised only when the winner outranks every level still marked in service. The master then pulses an acknowledge and reads back the winning level number. That level moves from the request register into the in-service register. An end-of-interrupt command later releases it.

Priority follows one of three orderings, which software can change at any moment. In the fixed ordering, level 0 is highest and level 7 is lowest. In the rotating ordering, each level that finishes service becomes the lowest. In the software-anchored ordering, software names the lowest level. In both of the last two, the other levels rank in circular order after that lowest level.

The host reaches the block through a byte-wide port at two addresses. A sticky read-select command decides which register the first address returns. The commands are told apart by their top two bits.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask, request and in-service registers read 0, the ordering is fixed, the read select points at the request register, and `int_out` is low.
- R2: A high level on `irq_req[n]` sets request bit n at the next clock. The bit stays set after the line drops, until level n is acknowledged. A read at `bus_sel`=0 with select 0xC0 returns the request register with masked bits included.
- R3: A write at `bus_sel`=1 loads the mask byte, and a read there returns it. A masked pending level raises neither `int_out` nor the poll valid flag.
- R4: In the fixed ordering (command 0x00, or 0x03) a lower level number outranks a higher one.
- R5: `int_out` is high only when an unmasked request exists whose rank is strictly better than the best in-service level. A request of equal or worse rank waits.
- R6: When `int_ack` is high in a cycle with `int_out` high, `ack_level` gives the winner. At the next clock the winner's in-service bit is set and its request bit is cleared. An `int_ack` while `int_out` is low changes nothing.
- R7: Command 0x40 clears the in-service bit of highest rank, and only that one.
- R8: In the rotating ordering (command 0x01), an end-of-interrupt makes the released level the lowest, so the level numbered one above it becomes the highest.
- R9: In the software-anchored ordering (command 0x02), command 0x80|n makes level n the lowest, and the ranking runs n+1, n+2 … n modulo 8.
- R10: With select 0xC2, a read at `bus_sel`=0 returns bit 7 as a valid flag and bits 2:0 as the highest-ranked unmasked pending level; all other bits are 0. Select 0xC1 returns the in-service register.
- R11: A change of ordering takes effect from the next clock. Returning to the fixed ordering ignores any stored lowest level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 8 | Level-sensitive request lines |
| bus_sel | input | 1 | Address select: 0 = command/selected read, 1 = mask |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| int_out | output | 1 | Interrupt to the bus master |
| int_ack | input | 1 | Acknowledge pulse from the master |
| ack_level | output | 3 | Level number of the current winner |

## Verification
The bench sends a lower-ranked request while a higher level is in service. A controller that only checked for pending requests would raise `int_out` there and break nesting. Rotation is tested with two requests pending across an end-of-interrupt: if the released level were not moved to the bottom, the wrong level would win the next acknowledge. The bench stores a lowest level of 5 and then switches to the fixed ordering. This catches a design that keeps applying the stored anchor, which would make level 6 win over level 0. A masked request is held pending while the bench watches `int_out` and the poll flag, to show that masking hides a request without discarding it.

// File: rtl/prio_pkg.sv
package prio_pkg;
  localparam int unsigned N_LEVELS = 8;
  localparam int unsigned LVL_W    = $clog2(N_LEVELS);

  typedef enum logic [1:0] {
    ORD_FIXED  = 2'd0,
    ORD_ROTATE = 2'd1,
    ORD_ANCHOR = 2'd2
  } order_e;

  typedef enum logic [1:0] {
    RSEL_REQ  = 2'd0,
    RSEL_ISR  = 2'd1,
    RSEL_POLL = 2'd2
  } rsel_e;

  // command opcode in bits 7:6
  localparam logic [1:0] OP_ORDER = 2'b00;
  localparam logic [1:0] OP_EOI   = 2'b01;
  localparam logic [1:0] OP_LOW   = 2'b10;
  localparam logic [1:0] OP_RSEL  = 2'b11;

  // level that holds a given rank (0 = best) when 'low' is the lowest level
  function automatic logic [LVL_W-1:0] level_at(input logic [LVL_W-1:0] rank,
                                                input logic [LVL_W-1:0] low);
    level_at = low + LVL_W'(1) + rank;
  endfunction

  // rank of a level (0 = best) when 'low' is the lowest level
  function automatic logic [LVL_W-1:0] rank_of(input logic [LVL_W-1:0] lvl,
                                               input logic [LVL_W-1:0] low);
    rank_of = lvl - low - LVL_W'(1);
  endfunction
endpackage

// File: rtl/prio_resolver.sv
module prio_resolver
  import prio_pkg::*;
(
  input  logic [N_LEVELS-1:0] vec,
  input  logic [LVL_W-1:0]    low,
  output logic                vld,
  output logic [LVL_W-1:0]    lvl,
  output logic [LVL_W-1:0]    rank
);
  always_comb begin
    vld  = 1'b0;
    lvl  = '0;
    rank = '0;
    for (int r = N_LEVELS - 1; r >= 0; r--) begin
      if (vec[level_at(LVL_W'(r), low)]) begin
        vld  = 1'b1;
        lvl  = level_at(LVL_W'(r), low);
        rank = LVL_W'(r);
      end
    end
  end
endmodule

// File: rtl/prio_host_port.sv
module prio_host_port
  import prio_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [7:0]          bus_wdata,
  input  logic [N_LEVELS-1:0] irr_q,
  input  logic [N_LEVELS-1:0] isr_q,
  input  logic                poll_vld,
  input  logic [LVL_W-1:0]    poll_lvl,
  output logic [N_LEVELS-1:0] mask_q,
  output order_e              order_q,
  output logic                low_set,
  output logic [LVL_W-1:0]    low_val,
  output logic                eoi_fire,
  output logic [7:0]          bus_rdata
);
  rsel_e rsel_q;
  logic  cmd_wr;
  logic [1:0] op;

  assign cmd_wr   = bus_wr && !bus_sel;
  assign op       = bus_wdata[7:6];
  assign eoi_fire = cmd_wr && (op == OP_EOI);
  assign low_set  = cmd_wr && (op == OP_LOW);
  assign low_val  = bus_wdata[LVL_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q  <= '0;
      order_q <= ORD_FIXED;
      rsel_q  <= RSEL_REQ;
    end else begin
      if (bus_wr && bus_sel) mask_q <= bus_wdata;
      if (cmd_wr && op == OP_ORDER) begin
        case (bus_wdata[1:0])
          2'd1:    order_q <= ORD_ROTATE;
          2'd2:    order_q <= ORD_ANCHOR;
          default: order_q <= ORD_FIXED;
        endcase
      end
      if (cmd_wr && op == OP_RSEL) begin
        case (bus_wdata[1:0])
          2'd1:    rsel_q <= RSEL_ISR;
          2'd2:    rsel_q <= RSEL_POLL;
          default: rsel_q <= RSEL_REQ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_sel) bus_rdata = mask_q;
      else begin
        case (rsel_q)
          RSEL_ISR:  bus_rdata = isr_q;
          RSEL_POLL: bus_rdata = {poll_vld, 7'(poll_vld ? poll_lvl : '0)};
          default:   bus_rdata = irr_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       irq_req,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             int_out,
  input  logic             int_ack,
  output logic [2:0]       ack_level
);
  logic [N_LEVELS-1:0] irr_q, isr_q, mask_q, pend;
  logic [LVL_W-1:0]    low_q, low_eff, low_val;
  order_e              order_q;
  logic                low_set, eoi_fire, ack_fire;
  logic                win_vld, isr_vld;
  logic [LVL_W-1:0]    win_lvl, win_rank, isr_top_lvl, isr_rank;

  prio_host_port u_port (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_rd, .bus_wdata,
    .irr_q, .isr_q, .poll_vld(win_vld), .poll_lvl(win_lvl),
    .mask_q, .order_q, .low_set, .low_val, .eoi_fire, .bus_rdata
  );

  assign low_eff = (order_q == ORD_FIXED) ? LVL_W'(N_LEVELS - 1) : low_q;
  assign pend    = irr_q & ~mask_q;

  prio_resolver u_win (.vec(pend),  .low(low_eff), .vld(win_vld), .lvl(win_lvl),     .rank(win_rank));
  prio_resolver u_svc (.vec(isr_q), .low(low_eff), .vld(isr_vld), .lvl(isr_top_lvl), .rank(isr_rank));

  assign int_out   = win_vld && (!isr_vld || win_rank < isr_rank);
  assign ack_level = win_lvl;
  assign ack_fire  = int_ack && int_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q <= '0;
      isr_q <= '0;
      low_q <= LVL_W'(N_LEVELS - 1);
    end else begin
      for (int i = 0; i < N_LEVELS; i++) begin
        if (ack_fire && win_lvl == LVL_W'(i))              irr_q[i] <= 1'b0;
        else                                               irr_q[i] <= irr_q[i] | irq_req[i];
        if (ack_fire && win_lvl == LVL_W'(i))              isr_q[i] <= 1'b1;
        else if (eoi_fire && isr_vld && isr_top_lvl == LVL_W'(i)) isr_q[i] <= 1'b0;
      end
      if (low_set)                                            low_q <= low_val;
      else if (eoi_fire && isr_vld && order_q == ORD_ROTATE)  low_q <= isr_top_lvl;
    end
  end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                int_out,
  input logic [N_LEVELS-1:0] mask_q,
  input logic [N_LEVELS-1:0] irr_q,
  input logic [N_LEVELS-1:0] isr_q,
  input logic [LVL_W-1:0]    win_lvl,
  input logic [LVL_W-1:0]    isr_top_lvl,
  input logic                ack_fire,
  input logic                eoi_fire,
  input logic                isr_vld,
  input order_e              order_q
);
  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_fire |=> (irr_q & $past(irr_q)) == $past(irr_q)); // R2
  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr_q & ~mask_q) != '0); // R3
  AST_TOP0_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (order_q == ORD_FIXED && isr_q[0]) |-> !int_out); // R4
  AST_ACKED_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_top_lvl == $past(win_lvl)); // R5
  AST_ACK_TO_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(win_lvl)]); // R6
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> !irr_q[$past(win_lvl)]); // R6
  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && isr_vld && !ack_fire) |=> $countones(isr_q) == $countones($past(isr_q)) - 1); // R7
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .int_out(int_out), .mask_q(mask_q), .irr_q(irr_q),
  .isr_q(isr_q), .win_lvl(win_lvl), .isr_top_lvl(isr_top_lvl), .ack_fire(ack_fire),
  .eoi_fire(eoi_fire), .isr_vld(isr_vld), .order_q(order_q)
);

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_req = '0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       int_out, int_ack = 1'b0;
  logic [2:0] ack_level;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (.clk, .rst_n, .irq_req, .bus_sel, .bus_wr, .bus_rd,
    .bus_wdata, .bus_rdata, .int_out, .int_ack, .ack_level);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk); bus_sel = s; bus_rd = 1'b1; #2; d = bus_rdata; bus_rd = 1'b0;
  endtask

  task automatic rd_sel(input logic [7:0] cmd, output logic [7:0] d);
    wr(1'b0, cmd); rd(1'b0, d);
  endtask

  task automatic pulse_irq(input logic [7:0] v);
    @(negedge clk); irq_req = v;
    @(negedge clk); irq_req = '0; #2;
  endtask

  task automatic ack(input string req, input logic [2:0] exp_lvl);
    @(negedge clk); #2;
    chk(req, {7'd0, int_out}, 8'd1);
    chk(req, {5'd0, ack_level}, {5'd0, exp_lvl});
    int_ack = 1'b1;
    @(negedge clk); int_ack = 1'b0; #2;
  endtask

  task automatic look_int(input string req, input logic exp);
    @(negedge clk); #2; chk(req, {7'd0, int_out}, {7'd0, exp});
  endtask

  task automatic t_reset;
    logic [7:0] d;
    look_int("R1 int_out", 1'b0);
    rd(1'b1, d); chk("R1 mask", d, 8'h00);
    rd(1'b0, d); chk("R1 request default sel", d, 8'h00);
    rd_sel(8'hC1, d); chk("R1 isr", d, 8'h00);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_latch;
    logic [7:0] d;
    pulse_irq(8'h20);
    rd(1'b0, d); chk("R2 held request", d, 8'h20);
    ack("R2 ack level 5", 3'd5);
    rd(1'b0, d); chk("R6 request cleared", d, 8'h00);
    rd_sel(8'hC1, d); chk("R6 isr set", d, 8'h20);
    wr(1'b0, 8'h40);
    rd(1'b0, d); chk("R7 isr released", d, 8'h00);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_ack_ignored;
    logic [7:0] d;
    @(negedge clk); int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
    rd_sel(8'hC1, d); chk("R6 stray ack", d, 8'h00);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(1'b1, 8'h01);
    pulse_irq(8'h01);
    look_int("R3 masked no int", 1'b0);
    rd(1'b1, d); chk("R3 mask readback", d, 8'h01);
    rd(1'b0, d); chk("R2 masked still latched", d, 8'h01);
    rd_sel(8'hC2, d); chk("R10 poll empty", d, 8'h00);
    wr(1'b1, 8'h00);
    ack("R3 unmasked level 0", 3'd0);
    wr(1'b0, 8'h40);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_nested;
    logic [7:0] d;
    pulse_irq(8'h90);
    ack("R4 level 4 over 7", 3'd4);
    look_int("R5 lower waits", 1'b0);
    pulse_irq(8'h04);
    ack("R5 level 2 preempts", 3'd2);
    rd_sel(8'hC1, d); chk("R6 isr nested", d, 8'h14);
    wr(1'b0, 8'h40);
    rd(1'b0, d); chk("R7 clears top only", d, 8'h10);
    look_int("R5 still blocked by 4", 1'b0);
    wr(1'b0, 8'h40);
    ack("R4 level 7 last", 3'd7);
    wr(1'b0, 8'h40);
    wr(1'b0, 8'hC0);
  endtask

  task automatic t_rotate;
    wr(1'b0, 8'h01);
    pulse_irq(8'h0C);
    ack("R8 first level 2", 3'd2);
    look_int("R5 level 3 waits", 1'b0);
    wr(1'b0, 8'h40);
    pulse_irq(8'h04);
    ack("R8 level 3 after rotation", 3'd3);
    look_int("R8 level 2 now lowest", 1'b0);
    wr(1'b0, 8'h40);
    ack("R8 level 2 finally", 3'd2);
    wr(1'b0, 8'h40);
  endtask

  task automatic t_anchor;
    logic [7:0] d;
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h85);
    pulse_irq(8'h41);
    rd_sel(8'hC2, d); chk("R9 R10 poll level 6", d, 8'h86);
    @(negedge clk); #2; chk("R9 ack_level 6", {5'd0, ack_level}, 8'd6);
    wr(1'b0, 8'h00);
    rd(1'b0, d); chk("R11 fixed ignores anchor", d, 8'h80);
    ack("R11 level 0 wins", 3'd0);
    look_int("R4 level 6 blocked", 1'b0);
    wr(1'b0, 8'h40);
    ack("R4 level 6 next", 3'd6);
    wr(1'b0, 8'h40);
    wr(1'b0, 8'hC0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_latch();
    t_ack_ignored();
    t_mask();
    t_nested();
    t_rotate();
    t_anchor();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule